// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Binary Counter

This block is a synchronous binary counter assembled from identical 4-bit slices. Each slice can be preset from parallel data, can count up or down, or can hold its value, and it reports when it has reached the last value of its counting direction. The slices are chained through their carry-in enables, not through their clocks, so every flip-flop in the chain changes on the same rising edge. The default build chains two slices into an 8-bit counter.

The counter is typically used as an event or interval counter whose width is set by the number of slices. A low level on the clear input empties the whole counter at once, without waiting for a clock edge. A low level on the load input presets it on the next edge. Otherwise it steps once per edge while both enables are high. The carry output of the top slice marks the terminal value of the whole chain, so further counters can be hung behind it.

Top module: `updn_cascade`

## Requirements
- R1: While `clr_n` is low, `count` is 0x00 at once, with no clock edge needed, and it stays 0x00 across rising edges.
- R2: Clear outranks load: with `clr_n` and `ld_n` both low across a rising edge, `count` stays 0x00.
- R3: With `clr_n` high and `ld_n` low at a rising edge, `count` takes `data` on that edge, whatever the enables and `up` are.
- R4: With `ld_n` high, `cnt_en` high, `cin_en` high and `up`=1, each rising edge adds one to `count`, and 0xFF wraps to 0x00.
- R5: With `ld_n` high, both enables high and `up`=0, each rising edge subtracts one from `count`, and 0x00 wraps to 0xFF.
- R6: With `ld_n` high and either `cnt_en` or `cin_en` low, `count` holds its value over a rising edge.
- R7: With `up`=1 and `cin_en`=1, `rco` is high in the same cycle in which `count` is 0xFF, whatever `cnt_en` is.
- R8: With `up`=0 and `cin_en`=1, `rco` is high in the same cycle in which `count` is 0x00, whatever `cnt_en` is.
- R9: `rco` is low whenever `cin_en` is low, and also whenever `count` is not the terminal value for the current direction.
- R10: The upper slice steps only when the lower nibble is at its terminal value for the current direction: up from 0x0F gives 0x10, and down from 0xF0 gives 0xEF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by every slice |
| clr_n | input | 1 | Active-low asynchronous clear of the whole count |
| ld_n | input | 1 | Active-low synchronous parallel preset |
| data | input | 8 | Preset value |
| cnt_en | input | 1 | Count enable, broadcast to all slices |
| cin_en | input | 1 | Carry-in enable into the lowest slice |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | 8 | Current count |
| rco | output | 1 | Ripple-carry out: chain at its terminal value while enabled |

## Verification
Clear acts in zero cycles, so the bench checks it a nanosecond after lowering `clr_n`, before any clock edge. Load, count and hold results appear one cycle later, on the edge that samples the inputs. The bench therefore drives every vector on the falling edge and reads `count` two nanoseconds after the following rising edge, with the inputs still applied. `rco` is combinational on `count`, `up` and `cin_en`, so it is read at that same moment and compared against the new count under the inputs that are still held.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Width of one counter slice.
    parameter int SLICE_W = 4;

    // Direction encoding on the up input.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Registered state of one slice.
    typedef struct packed {
        logic [SLICE_W-1:0] cnt;
    } slice_state_t;

endpackage

// File: rtl/updn_term.sv
// Terminal-value detector for one slice: all ones going up, all zeros going down.
module updn_term #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic         up,
    input  logic         cin_en,
    output logic         at_term,
    output logic         rco
);
    logic all_ones;
    logic all_zeros;

    always_comb begin
        all_ones  = &cnt;
        all_zeros = ~|cnt;
        at_term   = (up == updn_pkg::DIR_UP) ? all_ones : all_zeros;
        rco       = cin_en & at_term;
    end
endmodule

// File: rtl/updn_slice.sv
// One cascadable slice: clear, then load, then count, then hold.
module updn_slice
    import updn_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n,
    input  logic               ld_n,
    input  logic [SLICE_W-1:0] data,
    input  logic               cnt_en,
    input  logic               cin_en,
    input  logic               up,
    output logic [SLICE_W-1:0] count,
    output logic               rco
);
    localparam logic [SLICE_W-1:0] STEP = {{(SLICE_W-1){1'b0}}, 1'b1};

    slice_state_t st_d;
    slice_state_t st_q;
    logic         at_term;

    always_comb begin
        st_d = st_q;
        if (!ld_n) begin
            st_d.cnt = data;
        end else if (cnt_en && cin_en) begin
            if (up == DIR_UP) begin
                st_d.cnt = st_q.cnt + STEP;
            end else begin
                st_d.cnt = st_q.cnt - STEP;
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    updn_term #(.W(SLICE_W)) u_term (
        .cnt     (st_q.cnt),
        .up      (up),
        .cin_en  (cin_en),
        .at_term (at_term),
        .rco     (rco)
    );

    assign count = st_q.cnt;

    // at_term is kept for visibility of the ungated flag; rco is the gated form.
    logic unused_term;
    assign unused_term = at_term;
endmodule

// File: rtl/updn_cascade.sv
// Chain of NSLICE slices, carry-in of each fed by the ripple-carry of the one below.
module updn_cascade
    import updn_pkg::*;
#(
    parameter int NSLICE = 2,
    localparam int W = SLICE_W * NSLICE
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic [W-1:0] data,
    input  logic         cnt_en,
    input  logic         cin_en,
    input  logic         up,
    output logic [W-1:0] count,
    output logic         rco
);
    logic [NSLICE:0] chain;

    assign chain[0] = cin_en;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        updn_slice u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .ld_n   (ld_n),
            .data   (data[g*SLICE_W +: SLICE_W]),
            .cnt_en (cnt_en),
            .cin_en (chain[g]),
            .up     (up),
            .count  (count[g*SLICE_W +: SLICE_W]),
            .rco    (chain[g+1])
        );
    end

    assign rco = chain[NSLICE];
endmodule

// File: rtl/updn_cascade_chk.sv
module updn_cascade_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic         ld_n,
    input logic [W-1:0] data,
    input logic         cnt_en,
    input logic         cin_en,
    input logic         up,
    input logic [W-1:0] count,
    input logic         rco
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    // R1 / R2: count is zero whenever clear is low at an edge.
    a_r1_clear_zero: assert property (@(posedge clk) !clr_n |-> count == '0);

    // R3: synchronous load.
    a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> count == $past(data));

    // R4: count up with wrap.
    a_r4_up: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && cnt_en && cin_en && up) |=> count == $past(count) + ONE);

    // R5: count down with wrap.
    a_r5_down: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && cnt_en && cin_en && !up) |=> count == $past(count) - ONE);

    // R6: hold when an enable is low.
    a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(cnt_en && cin_en)) |=> $stable(count));

    // R7: terminal flag going up.
    a_r7_rco_up: assert property (@(posedge clk) disable iff (!clr_n)
        (up && cin_en && count == ALL1) |-> rco);

    // R8: terminal flag going down.
    a_r8_rco_down: assert property (@(posedge clk) disable iff (!clr_n)
        (!up && cin_en && count == '0) |-> rco);

    // R9: flag needs carry-in.
    a_r9_rco_gated: assert property (@(posedge clk) disable iff (!clr_n)
        rco |-> cin_en);
endmodule

bind updn_cascade updn_cascade_chk #(.W(W)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .ld_n   (ld_n),
    .data   (data),
    .cnt_en (cnt_en),
    .cin_en (cin_en),
    .up     (up),
    .count  (count),
    .rco    (rco)
);

// File: tb/updn_cascade_bench.sv
`timescale 1ns/1ps
module updn_cascade_bench;
    logic       clk = 1'b0;
    logic       clr_n;
    logic       ld_n;
    logic [7:0] data;
    logic       cnt_en;
    logic       cin_en;
    logic       up;
    logic [7:0] count;
    logic       rco;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    updn_cascade u_updn_cascade (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .data(data),
        .cnt_en(cnt_en), .cin_en(cin_en), .up(up),
        .count(count), .rco(rco)
    );

    // Vector: {ld_n, data[8], cnt_en, cin_en, up, exp_count[8], exp_rco}
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'hFE, 1'b1, 1'b1, 1'b1, 8'hFE, 1'b0}, // R3 load
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b1}, // R4 up, R7 flag
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R4 wrap up
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0}, // R5 wrap down
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'hFE, 1'b0}, // R5 down
        {1'b0, 8'h0F, 1'b1, 1'b1, 1'b1, 8'h0F, 1'b0}, // R3 load
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h10, 1'b0}, // R10 carry up
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'h0F, 1'b0}, // R10 borrow
        {1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h0F, 1'b0}, // R6 cnt_en low
        {1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b0}, // R6 cin_en low
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // R3 load, R9 gated
        {1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R8 flag, cnt_en low
        {1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b1}, // R7 flag, cnt_en low
        {1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0}, // R9 gated
        {1'b0, 8'h5A, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0}, // R3 load beats count
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h5B, 1'b0}, // R4 up
        {1'b0, 8'hF0, 1'b1, 1'b1, 1'b0, 8'hF0, 1'b0}, // R3 load
        {1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'hEF, 1'b0}  // R10 borrow across slices
    };

    task automatic check(input string req, input logic [7:0] exp_c, input logic exp_r);
        checks++;
        if (count !== exp_c || rco !== exp_r) begin
            errors++;
            $display("FAIL %s: count=%h rco=%b expected count=%h rco=%b",
                     req, count, rco, exp_c, exp_r);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: count=%h rco=%b expected completion", count, rco);
        finish_run();
    end

    initial begin
        clr_n = 1'b0; ld_n = 1'b1; data = 8'h00;
        cnt_en = 1'b0; cin_en = 1'b0; up = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", 8'h00, 1'b0);
        @(negedge clk);
        clr_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ld_n   = VEC[i][20];
            data   = VEC[i][19:12];
            cnt_en = VEC[i][11];
            cin_en = VEC[i][10];
            up     = VEC[i][9];
            @(posedge clk);
            #2;
            check($sformatf("vector %0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R1: asynchronous clear, count is 0xEF before this.
        @(negedge clk);
        ld_n = 1'b1; cnt_en = 1'b0; cin_en = 1'b0; up = 1'b1;
        #1;
        clr_n = 1'b0;
        #1;
        check("R1 async clear", 8'h00, 1'b0);

        // R2: clear outranks load over an edge.
        ld_n = 1'b0; data = 8'hA5;
        @(posedge clk);
        #2;
        check("R2 clear over load", 8'h00, 1'b0);
        @(negedge clk);
        ld_n = 1'b1;
        clr_n = 1'b1;

        // R8 after clear: down with carry-in at zero flags terminal.
        cin_en = 1'b1; up = 1'b0;
        #1;
        check("R8 zero down", 8'h00, 1'b1);

        // R4/R7: count up from 0xFE with rco seen then wrap.
        @(negedge clk);
        ld_n = 1'b0; data = 8'hFE; cnt_en = 1'b1; up = 1'b1;
        @(posedge clk);
        #2;
        check("R3 load FE", 8'hFE, 1'b0);
        @(negedge clk);
        ld_n = 1'b1;
        @(posedge clk);
        #2;
        check("R7 at FF", 8'hFF, 1'b1);
        @(posedge clk);
        #2;
        check("R4 wrap", 8'h00, 1'b0);

        finish_run();
    end
endmodule